// File: doc/BRIEF.md
# Next-Line Fetch Predictor

This block works in the instruction-fetch stage. Each cycle it takes the cache line index and way being fetched, and decides which line and way to fetch next. Every fetch group of four instruction slots, named by its line index and way, owns one next-line entry. That entry holds a predicted line index and a predicted way, so the following fetch needs only index bits and a way select, with no full address. Each slot of a group also owns a two-bit saturating history counter. Together with a decode hint that marks which slots hold branches, these counters decide whether the group ends in a taken branch. No target buffer is involved.

When the prediction is taken, the stored next entry is issued. Otherwise the predictor issues the next sequential index in the same way. The execute stage reports each resolved branch back through an update port. That report trains the slot counter, and on a mispredict it repairs the next entry and raises a one-cycle flush.

Top module: `nlp_fetch_predictor`

## Requirements
- R1: After reset every counter is 01 (weakly not-taken). Every next entry of group (i, w) holds index i+1 (modulo the index range) and way w, and `flush_o` is 0.
- R2: On a resolve, the counter of the reported group and slot goes up by one when taken and down by one when not taken. It saturates at 00 and 11.
- R3: `pred_taken_o` is 1 exactly when at least one slot whose bit is set in `br_mask_i` (bit s = slot s) has a counter of 10 or 11. Counters of slots whose mask bit is 0 are ignored.
- R4: When `pred_taken_o` is 1, `pred_idx_o`/`pred_way_o` equal the stored next entry of the fetched group. When it is 0, they equal `fetch_idx_i`+1 and `fetch_way_i`.
- R5: A resolve is a mispredict when the actual direction differs from `res_pred_taken_i`, or when it is taken and the stored next entry differs from the reported target. A taken mispredict writes the target index and way into that group's next entry. The counter updates at the same edge.
- R6: `flush_o` is 1 for exactly the cycle after a mispredicting resolve, and 0 otherwise.
- R7: A lookup in the same cycle as an update to the same group returns the values held before that update.
- R8: The sequential index wraps from the highest index to 0.
- R9: An update changes only the reported group and slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_idx_i | input | IDX_W | Line index of the current fetch group |
| fetch_way_i | input | WAY_W | Way of the current fetch group |
| br_mask_i | input | SLOTS | Decode hint: bit s set when slot s holds a branch |
| res_valid_i | input | 1 | Resolve report valid |
| res_idx_i | input | IDX_W | Line index of the resolved group |
| res_way_i | input | WAY_W | Way of the resolved group |
| res_slot_i | input | SLOT_W | Slot of the resolved branch |
| res_taken_i | input | 1 | Actual direction |
| res_pred_taken_i | input | 1 | Direction that was predicted |
| res_tgt_idx_i | input | IDX_W | Actual target line index |
| res_tgt_way_i | input | WAY_W | Actual target way |
| pred_idx_o | output | IDX_W | Predicted next line index |
| pred_way_o | output | WAY_W | Predicted next way |
| pred_taken_o | output | 1 | Prediction is taken |
| flush_o | output | 1 | One-cycle mispredict flush |

## Verification
A corrupt counter appears at the ports the first time that group is looked up with a mask bit set on the affected slot. In that same cycle the flag flips, and the issued index jumps between the sequential and stored values. A lost or misdirected next-entry write shows on the next taken lookup of the group, and also on the next taken resolve against it, which then flushes when it should not. The bench keeps a full shadow of every entry and counter, and it aims its resolves at a few groups so that counters reach both saturation ends and these paths are exercised within tens of cycles.

// File: rtl/nlp_pkg.sv
`timescale 1ns/1ps
package nlp_pkg;
  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic taken);
    logic [1:0] n;
    n = c;
    if (taken && c != CTR_ST) n = c + 2'd1;
    else if (!taken && c != CTR_SNT) n = c - 2'd1;
    return n;
  endfunction

  function automatic logic ctr_says_taken(input logic [1:0] c);
    return c[1];
  endfunction
endpackage

// File: rtl/nlp_next_table.sv
`timescale 1ns/1ps
module nlp_next_table #(
  parameter int IDX_W = 6,
  parameter int WAY_W = 1,
  localparam int SEL_W = IDX_W + WAY_W,
  localparam int ENTRIES = 1 << SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] lk_sel_i,
  output logic [IDX_W-1:0] lk_idx_o,
  output logic [WAY_W-1:0] lk_way_o,
  input  logic [SEL_W-1:0] rs_sel_i,
  output logic [IDX_W-1:0] rs_idx_o,
  output logic [WAY_W-1:0] rs_way_o,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [WAY_W-1:0] wr_way_i
);
  logic [IDX_W-1:0] nf_idx_q [ENTRIES];
  logic [WAY_W-1:0] nf_way_q [ENTRIES];

  // reset default: sequential line, same way
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < ENTRIES; e++) begin
        nf_idx_q[e] <= IDX_W'((e >> WAY_W) + 1);
        nf_way_q[e] <= WAY_W'(e);
      end
    end else if (wr_en_i) begin
      nf_idx_q[wr_sel_i] <= wr_idx_i;
      nf_way_q[wr_sel_i] <= wr_way_i;
    end
  end

  assign lk_idx_o = nf_idx_q[lk_sel_i];
  assign lk_way_o = nf_way_q[lk_sel_i];
  assign rs_idx_o = nf_idx_q[rs_sel_i];
  assign rs_way_o = nf_way_q[rs_sel_i];

  p_wr_lands_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (nf_idx_q[$past(wr_sel_i)] == $past(wr_idx_i)) &&
                (nf_way_q[$past(wr_sel_i)] == $past(wr_way_i)));
endmodule

// File: rtl/nlp_hist_table.sv
`timescale 1ns/1ps
module nlp_hist_table
  import nlp_pkg::*;
#(
  parameter int SEL_W = 7,
  parameter int SLOTS = 4,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int ENTRIES = 1 << SEL_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [SEL_W-1:0]      lk_sel_i,
  output logic [SLOTS-1:0][1:0] lk_cnt_o,
  input  logic                  upd_en_i,
  input  logic [SEL_W-1:0]      upd_sel_i,
  input  logic [SLOT_W-1:0]     upd_slot_i,
  input  logic                  upd_taken_i
);
  logic [1:0] cnt_q [ENTRIES][SLOTS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < ENTRIES; e++)
        for (int s = 0; s < SLOTS; s++)
          cnt_q[e][s] <= CTR_WNT;
    end else if (upd_en_i) begin
      cnt_q[upd_sel_i][upd_slot_i] <= ctr_step(cnt_q[upd_sel_i][upd_slot_i], upd_taken_i);
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_rd
    assign lk_cnt_o[s] = cnt_q[lk_sel_i][s];
  end

  p_sat_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && upd_taken_i && cnt_q[upd_sel_i][upd_slot_i] == CTR_ST)
      |=> cnt_q[$past(upd_sel_i)][$past(upd_slot_i)] == CTR_ST);
  p_sat_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !upd_taken_i && cnt_q[upd_sel_i][upd_slot_i] == CTR_SNT)
      |=> cnt_q[$past(upd_sel_i)][$past(upd_slot_i)] == CTR_SNT);
endmodule

// File: rtl/nlp_select.sv
`timescale 1ns/1ps
module nlp_select
  import nlp_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int WAY_W = 1,
  parameter int SLOTS = 4
) (
  input  logic [IDX_W-1:0]      fetch_idx_i,
  input  logic [WAY_W-1:0]      fetch_way_i,
  input  logic [SLOTS-1:0]      br_mask_i,
  input  logic [SLOTS-1:0][1:0] cnt_i,
  input  logic [IDX_W-1:0]      nf_idx_i,
  input  logic [WAY_W-1:0]      nf_way_i,
  output logic [IDX_W-1:0]      pred_idx_o,
  output logic [WAY_W-1:0]      pred_way_o,
  output logic                  pred_taken_o
);
  logic [SLOTS-1:0] vote;

  for (genvar s = 0; s < SLOTS; s++) begin : g_vote
    assign vote[s] = br_mask_i[s] & ctr_says_taken(cnt_i[s]);
  end

  assign pred_taken_o = |vote;
  assign pred_idx_o   = pred_taken_o ? nf_idx_i : fetch_idx_i + IDX_W'(1);
  assign pred_way_o   = pred_taken_o ? nf_way_i : fetch_way_i;
endmodule

// File: rtl/nlp_fetch_predictor.sv
`timescale 1ns/1ps
module nlp_fetch_predictor #(
  parameter int IDX_W = 6,
  parameter int WAYS  = 2,
  parameter int SLOTS = 4,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int SEL_W  = IDX_W + WAY_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  fetch_idx_i,
  input  logic [WAY_W-1:0]  fetch_way_i,
  input  logic [SLOTS-1:0]  br_mask_i,
  input  logic              res_valid_i,
  input  logic [IDX_W-1:0]  res_idx_i,
  input  logic [WAY_W-1:0]  res_way_i,
  input  logic [SLOT_W-1:0] res_slot_i,
  input  logic              res_taken_i,
  input  logic              res_pred_taken_i,
  input  logic [IDX_W-1:0]  res_tgt_idx_i,
  input  logic [WAY_W-1:0]  res_tgt_way_i,
  output logic [IDX_W-1:0]  pred_idx_o,
  output logic [WAY_W-1:0]  pred_way_o,
  output logic              pred_taken_o,
  output logic              flush_o
);
  logic [SEL_W-1:0]      lk_sel, rs_sel;
  logic [IDX_W-1:0]      lk_nf_idx, rs_nf_idx;
  logic [WAY_W-1:0]      lk_nf_way, rs_nf_way;
  logic [SLOTS-1:0][1:0] lk_cnt;
  logic                  dir_miss, tgt_miss, mispredict, flush_q;

  assign lk_sel = {fetch_idx_i, fetch_way_i};
  assign rs_sel = {res_idx_i, res_way_i};

  nlp_next_table #(.IDX_W(IDX_W), .WAY_W(WAY_W)) u_next (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lk_sel_i (lk_sel),
    .lk_idx_o (lk_nf_idx),
    .lk_way_o (lk_nf_way),
    .rs_sel_i (rs_sel),
    .rs_idx_o (rs_nf_idx),
    .rs_way_o (rs_nf_way),
    .wr_en_i  (mispredict & res_taken_i),
    .wr_sel_i (rs_sel),
    .wr_idx_i (res_tgt_idx_i),
    .wr_way_i (res_tgt_way_i)
  );

  nlp_hist_table #(.SEL_W(SEL_W), .SLOTS(SLOTS)) u_hist (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_sel_i    (lk_sel),
    .lk_cnt_o    (lk_cnt),
    .upd_en_i    (res_valid_i),
    .upd_sel_i   (rs_sel),
    .upd_slot_i  (res_slot_i),
    .upd_taken_i (res_taken_i)
  );

  nlp_select #(.IDX_W(IDX_W), .WAY_W(WAY_W), .SLOTS(SLOTS)) u_sel (
    .fetch_idx_i  (fetch_idx_i),
    .fetch_way_i  (fetch_way_i),
    .br_mask_i    (br_mask_i),
    .cnt_i        (lk_cnt),
    .nf_idx_i     (lk_nf_idx),
    .nf_way_i     (lk_nf_way),
    .pred_idx_o   (pred_idx_o),
    .pred_way_o   (pred_way_o),
    .pred_taken_o (pred_taken_o)
  );

  // stored target checked only when the branch was really taken
  assign dir_miss   = res_taken_i != res_pred_taken_i;
  assign tgt_miss   = res_taken_i && (rs_nf_idx != res_tgt_idx_i || rs_nf_way != res_tgt_way_i);
  assign mispredict = res_valid_i && (dir_miss || tgt_miss);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flush_q <= 1'b0;
    else         flush_q <= mispredict;
  end
  assign flush_o = flush_q;

  p_flush_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $past(res_valid_i));
  p_taken_needs_br_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_taken_o |-> (br_mask_i != '0));
  p_nt_sequential_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_taken_o |-> (pred_idx_o == IDX_W'(fetch_idx_i + 1)) && (pred_way_o == fetch_way_i));
  p_no_mask_nt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_mask_i == '0) |-> !pred_taken_o);
endmodule

// File: tb/nlp_fetch_predictor_tb.sv
`timescale 1ns/1ps
module nlp_fetch_predictor_tb_top;
  localparam int IDX_W = 6;
  localparam int WAYS  = 2;
  localparam int SLOTS = 4;
  localparam int WAY_W = 1;
  localparam int SLOT_W = 2;
  localparam int ENT = (1 << IDX_W) * WAYS;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [IDX_W-1:0]  fetch_idx = '0, res_idx = '0, res_tgt_idx = '0;
  logic [WAY_W-1:0]  fetch_way = '0, res_way = '0, res_tgt_way = '0;
  logic [SLOTS-1:0]  br_mask = '0;
  logic [SLOT_W-1:0] res_slot = '0;
  logic res_valid = 1'b0, res_taken = 1'b0, res_pred = 1'b0;
  logic [IDX_W-1:0] pred_idx;
  logic [WAY_W-1:0] pred_way;
  logic pred_taken, flush;

  nlp_fetch_predictor #(.IDX_W(IDX_W), .WAYS(WAYS), .SLOTS(SLOTS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_idx_i(fetch_idx), .fetch_way_i(fetch_way), .br_mask_i(br_mask),
    .res_valid_i(res_valid), .res_idx_i(res_idx), .res_way_i(res_way),
    .res_slot_i(res_slot), .res_taken_i(res_taken), .res_pred_taken_i(res_pred),
    .res_tgt_idx_i(res_tgt_idx), .res_tgt_way_i(res_tgt_way),
    .pred_idx_o(pred_idx), .pred_way_o(pred_way), .pred_taken_o(pred_taken),
    .flush_o(flush)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_idx [ENT];
  int m_way [ENT];
  int m_ctr [ENT][SLOTS];
  bit m_flush = 0;

  function automatic int sel_of(int idx, int way);
    return idx * WAYS + way;
  endfunction

  function automatic bit exp_taken();
    bit t = 0;
    for (int s = 0; s < SLOTS; s++)
      if (br_mask[s] && m_ctr[sel_of(fetch_idx, fetch_way)][s] >= 2) t = 1;
    return t;
  endfunction

  task automatic cmp(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int e = 0; e < ENT; e++) begin
      m_idx[e] = ((e / WAYS) + 1) % (1 << IDX_W);
      m_way[e] = e % WAYS;
      for (int s = 0; s < SLOTS; s++) m_ctr[e][s] = 1;
    end
    m_flush = 0;
  endtask

  // inputs already set; check before edge, then advance model at edge
  task automatic tick(string tag);
    bit t;
    int e, ei, ew;
    @(negedge clk);
    t = exp_taken();
    e = sel_of(fetch_idx, fetch_way);
    ei = t ? m_idx[e] : (fetch_idx + 1) % (1 << IDX_W);
    ew = t ? m_way[e] : fetch_way;
    cmp({tag, " taken R3"}, pred_taken, t);
    cmp({tag, " idx R4"}, pred_idx, ei);
    cmp({tag, " way R4"}, pred_way, ew);
    cmp({tag, " flush R6"}, flush, m_flush);
    @(posedge clk);
    if (res_valid) begin
      int r = sel_of(res_idx, res_way);
      bit miss = (res_taken != res_pred) ||
                 (res_taken && (m_idx[r] != res_tgt_idx || m_way[r] != res_tgt_way));
      if (res_taken && m_ctr[r][res_slot] < 3) m_ctr[r][res_slot]++;
      if (!res_taken && m_ctr[r][res_slot] > 0) m_ctr[r][res_slot]--;
      if (miss && res_taken) begin
        m_idx[r] = res_tgt_idx;
        m_way[r] = res_tgt_way;
      end
      m_flush = miss;
    end else m_flush = 0;
    #2;
  endtask

  task automatic resolve(int idx, int way, int slot, bit tk, bit pr, int ti, int tw);
    res_valid = 1; res_idx = IDX_W'(idx); res_way = WAY_W'(way); res_slot = SLOT_W'(slot);
    res_taken = tk; res_pred = pr; res_tgt_idx = IDX_W'(ti); res_tgt_way = WAY_W'(tw);
  endtask

  initial begin
    void'($urandom(32'd20250611));
    model_reset();
    #25;
    // R1: reset state visible at ports
    fetch_idx = 6'd5; fetch_way = 1'b1; br_mask = 4'hF;
    #1;
    cmp("reset taken R1", pred_taken, 0);
    cmp("reset idx R1", pred_idx, 6);
    cmp("reset way R1", pred_way, 1);
    cmp("reset flush R1", flush, 0);
    @(posedge clk); #2 rst_n = 1'b1;
    @(posedge clk); #2;

    // R2: train group (10,0) slot 2 to taken, with new target
    fetch_idx = 6'd10; fetch_way = 0; br_mask = 4'b0100;
    resolve(10, 0, 2, 1, 0, 33, 1); tick("train1 R5");
    res_valid = 0; tick("flush pulse R6");
    tick("flush clear R6");
    cmp("trained taken R2", pred_taken, 1);
    cmp("followed field R4", pred_idx, 33);
    // R3: mask excludes slot 2, counter ignored
    br_mask = 4'b1011; tick("mask ignore R3");
    cmp("masked nt R3", pred_taken, 0);
    // saturate high
    br_mask = 4'b0100;
    for (int k = 0; k < 4; k++) begin resolve(10, 0, 2, 1, 1, 33, 1); tick("sat hi R2"); end
    resolve(10, 0, 2, 0, 1, 0, 0); tick("dec1 R2");
    resolve(10, 0, 2, 0, 1, 0, 0); tick("dec2 R2");
    res_valid = 0; tick("after dec R2");
    cmp("two decs nt R2", pred_taken, 0);
    for (int k = 0; k < 4; k++) begin resolve(10, 0, 2, 0, 0, 0, 0); tick("sat lo R2"); end
    resolve(10, 0, 2, 1, 0, 33, 1); tick("inc from 0 R2");
    res_valid = 0; tick("still nt R2");
    // R7: same-cycle update returns old value
    resolve(10, 0, 2, 1, 0, 33, 1); tick("rbw R7");
    res_valid = 0; tick("after rbw R7");
    cmp("taken after rbw R7", pred_taken, 1);
    // R8: wrap
    fetch_idx = 6'd63; fetch_way = 1; br_mask = 0; tick("wrap R8");
    cmp("wrap idx R8", pred_idx, 0);
    // R9 / random mix
    for (int k = 0; k < 4000; k++) begin
      fetch_idx = ($urandom % 3 == 0) ? IDX_W'($urandom) : IDX_W'($urandom % 4);
      fetch_way = WAY_W'($urandom);
      br_mask = SLOTS'($urandom);
      if ($urandom % 4 != 0)
        resolve($urandom % 4, $urandom % 2, $urandom % 4, $urandom % 3 != 0,
                $urandom % 2, ($urandom % 2) ? 20 : ($urandom % 64), $urandom % 2);
      else res_valid = 0;
      tick("random R9");
    end
    res_valid = 0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule